// File: doc/BRIEF.md
# DDR2 Bank Command Timing Checker

This block watches a DDR2 command bus (chip select, row strobe, column strobe, write enable, bank address and row address) one clock at a time. It checks the protocol. Each cycle it decodes the command on the pins. It tracks which of the eight banks holds an open row, and which row that is. It counts the cycles since the last accepted ACTIVE per bank, the last accepted ACTIVE on any bank, and the last accepted LOAD MODE. When a command breaks an ordering rule or a minimum-spacing rule, the block reports it. The report is a one-cycle error pulse with a 3-bit error code and the bank address of the offending command.

Spacing limits are parameters counted in clock cycles. The package holds a helper function that turns a limit in picoseconds into a cycle count. It divides by the clock period and rounds up. The block only observes: it drives nothing onto the memory bus. A command that breaks a rule is reported and then treated as if it never happened, so no bank state changes. Data-bus checks, refresh, power-down and mode register contents are outside its scope.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: After a synchronous reset, every bank is idle, no error is reported, and all spacing counters are saturated, so the first commands after reset are never rejected for timing.
- R2: Commands are decoded from {cs_n,ras_n,cas_n,we_n}: 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0000 LOAD MODE, 0111 NOP. Any cycle with cs_n=1 is a deselect. A deselect or a NOP never raises an error and never changes bank state, whatever the other pins carry.
- R3: An accepted ACTIVE sets bit `ba` of `bank_open` and places the row address on slice `ba` of `bank_row` (bits ba*ROW_W upward).
- R4: A READ or WRITE to a bank with no open row is rejected with code 1.
- R5: A READ or WRITE that comes fewer than T_RCD cycles after that bank's last accepted ACTIVE is rejected with code 2.
- R6: An ACTIVE to a bank that already has an open row is rejected with code 3.
- R7: An ACTIVE that comes fewer than T_RC cycles after the last accepted ACTIVE to the same bank is rejected with code 4.
- R8: An ACTIVE to a bank other than the one that received the last accepted ACTIVE, coming fewer than T_RRD cycles after that ACTIVE, is rejected with code 5.
- R9: A PRECHARGE closes bank `ba`. With addr bit 10 high it closes every bank. A PRECHARGE to an idle bank is legal.
- R10: A LOAD MODE while any bank has an open row is rejected with code 6.
- R11: An executable command (ACTIVE, READ, WRITE, PRECHARGE or LOAD MODE) that comes fewer than T_MRD cycles after the last accepted LOAD MODE is rejected with code 7. This check takes precedence over every other code.
- R12: A rejection appears on `err_valid`, `err_code` and `err_bank` (equal to the command's `ba`) in the cycle after the command is sampled. With no rejection, all three are zero. A rejected command changes no bank state and restarts no counter.
- R13: The package function `ps_to_cycles(spec_ps, tck_ps)` returns the limit divided by the period, rounded up. For example, (20000, 3750) gives 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ROW_W | Row address; bit 10 selects all banks on PRECHARGE |
| err_valid | output | 1 | One-cycle pulse per rejected command |
| err_code | output | 3 | Violation code, 1 to 7 |
| err_bank | output | BA_W | Bank address of the rejected command |
| bank_open | output | 2**BA_W | One bit per bank, set while a row is open |
| bank_row | output | 2**BA_W*ROW_W | Row held by each bank, packed bank by bank |

## Verification
The bench probes the exact boundary of each spacing limit. It issues the command one cycle before the limit and again on the limit. An off-by-one counter would therefore either accept the early command or reject the legal one. A rejected ACTIVE is followed by a repeat that is legal only when measured from the earlier accepted ACTIVE, so a design that let rejected commands restart counters or open banks would flag the repeat. A READ to an idle bank issued inside the LOAD MODE window must report code 7 rather than 1, which exposes a wrong priority order. Deselect cycles carrying ACTIVE-like pins, and a LOAD MODE rejected while a bank is open, show whether a design wrongly acts on ignored or rejected commands.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [2:0] {
        C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_LM, C_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_NO_ROW  = 3'd1,
        E_RCD     = 3'd2,
        E_OPEN    = 3'd3,
        E_RC      = 3'd4,
        E_RRD     = 3'd5,
        E_LM_BUSY = 3'd6,
        E_MRD     = 3'd7
    } err_e;

    // Convert a limit in picoseconds into whole clock cycles, rounding up.
    function automatic int unsigned ps_to_cycles(int unsigned spec_ps, int unsigned tck_ps);
        return (spec_ps + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/cg_decode.sv
module cg_decode
    import cg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        casez ({cs_n, ras_n, cas_n, we_n})
            4'b1???: cmd = C_DESEL;
            4'b0111: cmd = C_NOP;
            4'b0011: cmd = C_ACT;
            4'b0101: cmd = C_RD;
            4'b0100: cmd = C_WR;
            4'b0010: cmd = C_PRE;
            4'b0000: cmd = C_LM;
            default: cmd = C_OTHER;
        endcase
    end
endmodule

// File: rtl/cg_satcnt.sv
module cg_satcnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = CW'(1);
        else if (cnt_q != '1)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/cg_bank.sv
module cg_bank #(
    parameter int ROW_W = 13,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_go,
    input  logic             close_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row,
    output logic [CW-1:0]    since_act
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (open_go) begin
            st_d.open = 1'b1;
            st_d.row  = row_in;
        end else if (close_go) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    cg_satcnt #(.CW(CW)) u_act_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (open_go),
        .count   (since_act)
    );

    assign is_open = st_q.open;
    assign row     = st_q.row;
endmodule

// File: rtl/ddr2_cmd_guard.sv
module ddr2_cmd_guard
    import cg_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BA_W   = 3,
    parameter int AP_BIT = 10,
    parameter int TCK_PS = 5000,
    parameter int T_RCD  = int'(ps_to_cycles(15000, TCK_PS)),
    parameter int T_RC   = int'(ps_to_cycles(40000, TCK_PS)),
    parameter int T_RRD  = int'(ps_to_cycles(7500, TCK_PS)),
    parameter int T_MRD  = 2,
    localparam int NBANK = 1 << BA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    output logic                   err_valid,
    output logic [2:0]             err_code,
    output logic [BA_W-1:0]        err_bank,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] bank_row
);
    localparam int T_MAX_A = (T_RCD > T_RC) ? T_RCD : T_RC;
    localparam int T_MAX_B = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CW      = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] RCD_C = CW'(T_RCD);
    localparam logic [CW-1:0] RC_C  = CW'(T_RC);
    localparam logic [CW-1:0] RRD_C = CW'(T_RRD);
    localparam logic [CW-1:0] MRD_C = CW'(T_MRD);

    typedef struct packed {
        logic            err_valid;
        err_e            code;
        logic [BA_W-1:0] err_bank;
        logic [BA_W-1:0] last_act;
    } top_s;

    top_s st_d, st_q;

    cmd_e            cmd;
    logic [NBANK-1:0] act_go, close_go;
    logic [CW-1:0]   since_act [NBANK];
    logic [CW-1:0]   rrd_cnt, lm_cnt;
    logic            rrd_restart, lm_restart;
    err_e            viol;
    logic            executable;

    cg_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cg_bank #(.ROW_W(ROW_W), .CW(CW)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .open_go   (act_go[b]),
            .close_go  (close_go[b]),
            .row_in    (addr),
            .is_open   (bank_open[b]),
            .row       (bank_row[b*ROW_W +: ROW_W]),
            .since_act (since_act[b])
        );
    end

    cg_satcnt #(.CW(CW)) u_rrd_cnt (
        .clk (clk), .rst (rst), .restart (rrd_restart), .count (rrd_cnt)
    );

    cg_satcnt #(.CW(CW)) u_mrd_cnt (
        .clk (clk), .rst (rst), .restart (lm_restart), .count (lm_cnt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.err_valid = 1'b0;
        st_d.code      = E_NONE;
        st_d.err_bank  = '0;
        act_go         = '0;
        close_go       = '0;
        rrd_restart    = 1'b0;
        lm_restart     = 1'b0;
        viol           = E_NONE;

        executable = (cmd == C_ACT) || (cmd == C_RD) || (cmd == C_WR) ||
                     (cmd == C_PRE) || (cmd == C_LM);

        // Rule ladder: mode-register window first, then per-command rules.
        if (executable && (lm_cnt < MRD_C)) begin
            viol = E_MRD;
        end else begin
            case (cmd)
                C_ACT: begin
                    if (bank_open[ba])
                        viol = E_OPEN;
                    else if (since_act[ba] < RC_C)
                        viol = E_RC;
                    else if ((ba != st_q.last_act) && (rrd_cnt < RRD_C))
                        viol = E_RRD;
                end
                C_RD, C_WR: begin
                    if (!bank_open[ba])
                        viol = E_NO_ROW;
                    else if (since_act[ba] < RCD_C)
                        viol = E_RCD;
                end
                C_LM: begin
                    if (|bank_open)
                        viol = E_LM_BUSY;
                end
                default: ;
            endcase
        end

        if (viol != E_NONE) begin
            st_d.err_valid = 1'b1;
            st_d.code      = viol;
            st_d.err_bank  = ba;
        end else begin
            case (cmd)
                C_ACT: begin
                    act_go[ba]    = 1'b1;
                    rrd_restart   = 1'b1;
                    st_d.last_act = ba;
                end
                C_PRE: begin
                    if (addr[AP_BIT]) close_go     = '1;
                    else              close_go[ba] = 1'b1;
                end
                C_LM: lm_restart = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign err_valid = st_q.err_valid;
    assign err_code  = st_q.code;
    assign err_bank  = st_q.err_bank;
endmodule

// File: rtl/cg_guard_chk.sv
module cg_guard_chk #(
    parameter int BA_W  = 3,
    parameter int NBANK = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             err_valid,
    input logic [2:0]       err_code,
    input logic [BA_W-1:0]  err_bank,
    input logic [NBANK-1:0] bank_open
);
    // R2
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!err_valid && $stable(bank_open)));

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && cas_n && we_n) |=> (!err_valid && $stable(bank_open)));

    // R12
    reject_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $stable(bank_open));

    // R12
    quiet_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> (err_code == 3'd0 && err_bank == '0));

    // R3
    single_open_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_open & ~$past(bank_open)) <= 1);
endmodule

bind ddr2_cmd_guard cg_guard_chk #(.BA_W(BA_W), .NBANK(NBANK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .err_valid (err_valid),
    .err_code  (err_code),
    .err_bank  (err_bank),
    .bank_open (bank_open)
);

// File: tb/sim_ddr2_cmd_guard.sv
`timescale 1ns/1ps
module sim_ddr2_cmd_guard;
    localparam int ROW_W = 13;
    localparam int BA_W  = 3;
    localparam int NB    = 8;

    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_LM  = 4'b0000;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DES = 4'b1111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BA_W-1:0]     ba = '0;
    logic [ROW_W-1:0]    addr = '0;
    logic                err_valid;
    logic [2:0]          err_code;
    logic [BA_W-1:0]     err_bank;
    logic [NB-1:0]       bank_open;
    logic [NB*ROW_W-1:0] bank_row;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ddr2_cmd_guard u0 (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .addr (addr), .err_valid (err_valid),
        .err_code (err_code), .err_bank (err_bank), .bank_open (bank_open),
        .bank_row (bank_row)
    );

    task automatic pins(input logic [3:0] p, input int b, input int a);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba   = BA_W'(b);
        addr = ROW_W'(a);
    endtask

    // Drive one command for one cycle; returns at the next falling edge.
    task automatic send(input logic [3:0] p, input int b, input int a);
        pins(p, b, a);
        @(negedge clk);
        pins(P_DES, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pins(P_DES, 0, 0);
        idle(3);
        rst = 1'b0;
    endtask

    task automatic exp_err(input logic [2:0] code, input int b, input string tag);
        logic [BA_W+3:0] got, want;
        got  = {err_valid, err_code, err_bank};
        want = {(code != 3'd0), code, (code != 3'd0) ? BA_W'(b) : BA_W'(0)};
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: err v/code/bank got %b/%0d/%0d expected %b/%0d/%0d",
                     tag, err_valid, err_code, err_bank, want[BA_W+3], code,
                     want[BA_W-1:0]);
        end
    endtask

    task automatic exp_open(input logic [NB-1:0] m, input string tag);
        n_chk++;
        if (bank_open !== m) begin
            n_fail++;
            $display("FAIL %s: bank_open got %b expected %b", tag, bank_open, m);
        end
    endtask

    task automatic exp_row(input int b, input int r, input string tag);
        n_chk++;
        if (bank_row[b*ROW_W +: ROW_W] !== ROW_W'(r)) begin
            n_fail++;
            $display("FAIL %s: row of bank %0d got %h expected %h", tag, b,
                     bank_row[b*ROW_W +: ROW_W], ROW_W'(r));
        end
    endtask

    task automatic exp_int(input int got, input int want, input string tag);
        n_chk++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, want);
        end
    endtask

    task automatic t_reset();
        do_reset();
        exp_open('0, "R1 banks idle after reset");
        exp_err(0, 0, "R1 no error after reset");
        send(P_LM, 0, 0);
        exp_err(0, 0, "R1 LOAD MODE right after reset");
        do_reset();
        send(P_ACT, 5, 7);
        exp_err(0, 0, "R1 ACTIVE right after reset");
        exp_open(8'h20, "R1 first ACTIVE opens");
    endtask

    task automatic t_ignored();
        do_reset();
        pins(P_ACT | 4'b1000, 2, 3);
        @(negedge clk);
        pins(P_DES, 0, 0);
        exp_err(0, 0, "R2 deselect with ACTIVE pins");
        exp_open('0, "R2 deselect opens nothing");
        send(P_NOP, 7, 1024);
        exp_err(0, 0, "R2 NOP no error");
        exp_open('0, "R2 NOP changes nothing");
        send(P_RD | 4'b1000, 4, 0);
        exp_err(0, 0, "R2 deselect with READ pins to idle bank");
    endtask

    task automatic t_activate();
        do_reset();
        send(P_ACT, 3, 'h1ABC);
        exp_err(0, 0, "R3 ACTIVE accepted");
        exp_open(8'h08, "R3 bank 3 open");
        exp_row(3, 'h1ABC, "R3 row of bank 3");
        idle(1);
        send(P_ACT, 7, 'h0055);
        exp_open(8'h88, "R3 banks 3 and 7 open");
        exp_row(7, 'h0055, "R3 row of bank 7");
    endtask

    task automatic t_rw_idle();
        do_reset();
        send(P_RD, 5, 0);
        exp_err(1, 5, "R4 READ to idle bank");
        send(P_WR, 5, 0);
        exp_err(1, 5, "R4 WRITE to idle bank");
    endtask

    task automatic t_rcd();
        do_reset();
        send(P_ACT, 2, 9);
        send(P_RD, 2, 0);
        exp_err(2, 2, "R5 READ one cycle after ACTIVE");
        send(P_RD, 2, 0);
        exp_err(2, 2, "R5 READ at T_RCD-1");
        send(P_WR, 2, 0);
        exp_err(0, 0, "R5 WRITE at T_RCD");
    endtask

    task automatic t_open_bank();
        do_reset();
        send(P_ACT, 4, 1);
        idle(9);
        send(P_ACT, 4, 2);
        exp_err(3, 4, "R6 ACTIVE to open bank");
        exp_row(4, 1, "R12 rejected ACTIVE keeps row");
        send(P_PRE, 4, 0);
        exp_err(0, 0, "R9 PRECHARGE accepted");
        exp_open('0, "R9 bank 4 closed");
        send(P_ACT, 4, 3);
        exp_err(0, 0, "R12 rejected ACTIVE restarted no counter");
        exp_open(8'h10, "R6 reopen after precharge");
    endtask

    task automatic t_rc();
        do_reset();
        send(P_ACT, 1, 0);
        send(P_PRE, 1, 0);
        send(P_ACT, 1, 0);
        exp_err(4, 1, "R7 ACTIVE 2 cycles after same-bank ACTIVE");
        idle(4);
        send(P_ACT, 1, 0);
        exp_err(4, 1, "R7 ACTIVE at T_RC-1");
        send(P_ACT, 1, 0);
        exp_err(0, 0, "R7 ACTIVE at T_RC");
        exp_open(8'h02, "R7 bank 1 reopened");
    endtask

    task automatic t_rrd();
        do_reset();
        send(P_ACT, 0, 0);
        send(P_ACT, 1, 0);
        exp_err(5, 1, "R8 ACTIVE other bank at T_RRD-1");
        exp_open(8'h01, "R12 rejected ACTIVE leaves bank closed");
        send(P_ACT, 1, 0);
        exp_err(0, 0, "R8 ACTIVE other bank at T_RRD");
        exp_open(8'h03, "R8 both banks open");
    endtask

    task automatic t_precharge();
        do_reset();
        send(P_ACT, 0, 0);
        idle(1);
        send(P_ACT, 6, 0);
        idle(1);
        send(P_ACT, 3, 0);
        exp_open(8'h49, "R9 three banks open");
        send(P_PRE, 3, 0);
        exp_open(8'h41, "R9 single-bank precharge");
        send(P_PRE, 5, 0);
        exp_err(0, 0, "R9 precharge of idle bank legal");
        exp_open(8'h41, "R9 idle precharge changes nothing");
        send(P_PRE, 0, 1 << 10);
        exp_open('0, "R9 precharge all");
    endtask

    task automatic t_lm_busy();
        do_reset();
        send(P_ACT, 0, 0);
        idle(2);
        send(P_LM, 1, 0);
        exp_err(6, 1, "R10 LOAD MODE with open bank");
        send(P_PRE, 0, 1 << 10);
        exp_err(0, 0, "R12 rejected LOAD MODE opened no window");
        send(P_LM, 2, 0);
        exp_err(0, 0, "R10 LOAD MODE with all idle");
    endtask

    task automatic t_mrd();
        do_reset();
        send(P_LM, 0, 0);
        send(P_ACT, 1, 0);
        exp_err(7, 1, "R11 ACTIVE inside mode window");
        exp_open('0, "R11 rejected ACTIVE opens nothing");
        send(P_NOP, 0, 0);
        exp_err(0, 0, "R11 NOP inside window");
        send(P_ACT, 1, 0);
        exp_err(0, 0, "R11 ACTIVE after window");
        send(P_PRE, 0, 1 << 10);
        send(P_LM, 0, 0);
        send(P_RD, 3, 0);
        exp_err(7, 3, "R11 window beats idle-bank READ");
    endtask

    task automatic t_conv();
        exp_int(int'(cg_pkg::ps_to_cycles(20000, 3750)), 6, "R13 20ns at 3.75ns");
        exp_int(int'(cg_pkg::ps_to_cycles(15000, 5000)), 3, "R13 exact multiple");
        exp_int(int'(cg_pkg::ps_to_cycles(7500, 5000)), 2, "R13 round up");
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_ignored();
        t_activate();
        t_rw_idle();
        t_rcd();
        t_open_bank();
        t_rc();
        t_rrd();
        t_precharge();
        t_lm_busy();
        t_mrd();
        t_conv();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule